// File: doc/BRIEF.md
# Ramping Stereo Digital Attenuator

This block scales a stereo PCM stream by a gain code. The gain does not jump when a new level is requested. Instead it slews toward the requested level by one code on every sample frame. Software, or a neighbouring block, writes a target gain at any moment. The running gain then heads for that target from wherever it currently stands. This holds even in the middle of a ramp, which may mean carrying on past an earlier target or turning round. The gain code has ten fractional bits: 0x400 is unity and 0x000 is silence. A full ramp from silence to unity therefore takes 1024 frames, about 23.2 ms at 44.1 kHz.

Each frame strobe presents one left and one right sample. On the strobe edge, both samples are multiplied by the gain in force for that frame and shifted right arithmetically by ten bits. The result is clamped symmetrically to the sample width and registered. On the same edge the gain takes its one-code step.

The gain controller is a three-state machine:
- **ST_HOLD**: gain equals target.
- **ST_RISE**: gain is below target.
- **ST_FALL**: gain is above target.

The transitions are named as follows:
- **go_up**: ST_HOLD to ST_RISE, when a target above the gain is written.
- **go_down**: ST_HOLD to ST_FALL, when a target below the gain is written.
- **arrive**: ST_RISE or ST_FALL to ST_HOLD, when a step or a write makes gain equal target.
- **turn_down**: ST_RISE to ST_FALL, when a write puts the target below the gain.
- **turn_up**: ST_FALL to ST_RISE, when a write puts the target above the gain.

The state is re-evaluated every cycle from the next gain and the next target.

Top module: `ramp_attenuator`

## Requirements
- R1: After reset the current gain is 0x000, the target is 0x000, and both output samples are 0.
- R2: A target write with a value above 0x400 stores 0x400, so the gain never exceeds 0x400.
- R3: On each cycle with the frame strobe high, the gain moves exactly one code toward the target. On cycles without the strobe, the gain does not change.
- R4: Once the gain equals the target, further strobes leave it unchanged.
- R5: A target written before the previous one is reached takes over from the present gain. A target beyond the old one is passed through without any pause at the old value.
- R6: A target written on the opposite side of the present gain reverses the ramp at the next strobe, one code from where the gain stood.
- R7: On a strobe edge each output becomes clamp(floor(input × G / 1024)), where G is the gain before that edge's step. Outputs hold between strobes.
- R8: Saturation is symmetric: outputs are limited to ±(2^(W−1)−1), so a most-negative input at unity gives −(2^(W−1)−1).
- R9: When a target write and a strobe coincide, that strobe steps toward the previously stored target. The new target governs from the following strobe.
- R10: Starting from 0x000 with target 0x400, the gain reads 0x3FF after 1023 strobes and 0x400 after 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking a new stereo frame on in_l/in_r |
| in_l | input | SAMPLE_W | Left input sample, two's complement |
| in_r | input | SAMPLE_W | Right input sample, two's complement |
| tgt_we | input | 1 | Target gain write enable |
| tgt_val | input | GAIN_W | Target gain code (0x400 = unity) |
| out_l | output | SAMPLE_W | Scaled left sample, registered |
| out_r | output | SAMPLE_W | Scaled right sample, registered |
| gain_now | output | GAIN_W | Current gain code |

## Verification
The assertions assume that frame_stb is a single-cycle pulse per frame. They assume that tgt_val is only meaningful while tgt_we is high, and that reset is held across at least one clock edge. The bench drives every strobe and write for exactly one cycle from the falling clock edge. It uses target values that include out-of-range codes and writes that land on a strobe cycle. It feeds samples that reach both rails, so the clamp and the coincident-write ordering are exercised within those input rules.

// File: rtl/ramp_att_pkg.sv
package ramp_att_pkg;

    // Direction of the gain controller relative to its target
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/tgt_clamp.sv
module tgt_clamp #(
    parameter int GAIN_W = 11
) (
    input  logic [GAIN_W-1:0] raw_i,
    output logic [GAIN_W-1:0] lim_o
);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

    always_comb begin
        lim_o = (raw_i > UNITY) ? UNITY : raw_i;
    end

    // R2: a stored target can never be above unity
    always_comb begin
        assert_clamp_range_R2: assert (lim_o <= UNITY);
    end
endmodule

// File: rtl/gain_ramp_fsm.sv
module gain_ramp_fsm
    import ramp_att_pkg::*;
#(
    parameter int GAIN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              tgt_we,
    input  logic [GAIN_W-1:0] tgt_lim,
    output logic [GAIN_W-1:0] gain_o
);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

    ramp_state_e       state_q, state_d;
    logic [GAIN_W-1:0] gain_q, gain_d;
    logic [GAIN_W-1:0] tgt_q, tgt_d;

    // Next gain, next target and next state
    always_comb begin
        gain_d = gain_q;
        if (frame_stb) begin
            unique case (state_q)
                ST_RISE: gain_d = gain_q + 1'b1;
                ST_FALL: gain_d = gain_q - 1'b1;
                ST_HOLD: gain_d = gain_q;
                default: gain_d = gain_q;
            endcase
        end
        // a write lands after this edge's step (R9)
        tgt_d = tgt_we ? tgt_lim : tgt_q;
        if (gain_d < tgt_d) begin
            state_d = ST_RISE;       // go_up / turn_up
        end else if (gain_d > tgt_d) begin
            state_d = ST_FALL;       // go_down / turn_down
        end else begin
            state_d = ST_HOLD;       // arrive
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            gain_q  <= '0;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            gain_q  <= gain_d;
            tgt_q   <= tgt_d;
        end
    end

    // Outputs
    always_comb begin
        gain_o = gain_q;
    end

    // R3: exactly one code of movement per strobe, none without
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (gain_q == $past(gain_q) + 1'b1) ||
                      (gain_q == $past(gain_q) - 1'b1) ||
                      (gain_q == $past(gain_q)));
    assert_no_strobe_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(gain_q));
    // R4: parked at target stays parked when target is not rewritten
    assert_hold_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !tgt_we && gain_q == tgt_q) |=> $stable(gain_q));
    // R5: below target, a strobe always moves the gain up
    assert_rise_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && gain_q < tgt_q) |=> gain_q == $past(gain_q) + 1'b1);
    // R6: above target, a strobe always moves the gain down
    assert_fall_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && gain_q > tgt_q) |=> gain_q == $past(gain_q) - 1'b1);
    // R2: gain never beyond unity
    assert_gain_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= UNITY);
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [GAIN_W-1:0]   gain_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    localparam int PW    = SAMPLE_W + GAIN_W + 1;
    localparam int SHIFT = GAIN_W - 1;
    localparam logic signed [PW-1:0] SAT_HI =
        {{(PW - SAMPLE_W + 1){1'b0}}, {(SAMPLE_W - 1){1'b1}}};
    localparam logic signed [PW-1:0] SAT_LO = -SAT_HI;
    localparam logic signed [SAMPLE_W-1:0] MOST_NEG =
        {1'b1, {(SAMPLE_W - 1){1'b0}}};

    logic signed [PW-1:0]       s_ext, g_ext, prod, shifted, sat;
    logic signed [SAMPLE_W-1:0] out_q;

    always_comb begin
        s_ext   = {{(GAIN_W + 1){sample_i[SAMPLE_W-1]}}, sample_i};
        g_ext   = {{(SAMPLE_W + 1){1'b0}}, gain_i};
        prod    = s_ext * g_ext;
        shifted = prod >>> SHIFT;
        if (shifted > SAT_HI) begin
            sat = SAT_HI;
        end else if (shifted < SAT_LO) begin
            sat = SAT_LO;
        end else begin
            sat = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (load) begin
            out_q <= sat[SAMPLE_W-1:0];
        end
    end

    assign sample_o = out_q;

    // R8: the asymmetric rail value is never produced
    assert_sym_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q != MOST_NEG);
    // R7: outputs hold between strobes
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_q));
    // R7: zero gain always silences
    assert_mute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gain_i == '0) |=> out_q == '0);
endmodule

// File: rtl/ramp_attenuator.sv
module ramp_attenuator #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_stb,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    input  logic                       tgt_we,
    input  logic        [GAIN_W-1:0]   tgt_val,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r,
    output logic        [GAIN_W-1:0]   gain_now
);
    localparam int NUM_CH = 2;

    logic [GAIN_W-1:0]          tgt_lim;
    logic [GAIN_W-1:0]          gain_cur;
    logic signed [SAMPLE_W-1:0] ch_in  [NUM_CH];
    logic signed [SAMPLE_W-1:0] ch_out [NUM_CH];

    tgt_clamp #(.GAIN_W(GAIN_W)) u_clamp (
        .raw_i (tgt_val),
        .lim_o (tgt_lim)
    );

    gain_ramp_fsm #(.GAIN_W(GAIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .tgt_we    (tgt_we),
        .tgt_lim   (tgt_lim),
        .gain_o    (gain_cur)
    );

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sample_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (frame_stb),
            .sample_i (ch_in[c]),
            .gain_i   (gain_cur),
            .sample_o (ch_out[c])
        );
    end

    assign out_l    = ch_out[0];
    assign out_r    = ch_out[1];
    assign gain_now = gain_cur;
endmodule

// File: tb/ramp_attenuator_tb_top.sv
module ramp_attenuator_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_stb = 1'b0;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic               tgt_we = 1'b0;
    logic [10:0]        tgt_val = '0;
    logic signed [15:0] out_l, out_r;
    logic [10:0]        gain_now;

    int checks = 0;
    int errors = 0;
    int mgain = 0;
    int mtgt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ramp_attenuator dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .in_l(in_l), .in_r(in_r), .tgt_we(tgt_we), .tgt_val(tgt_val),
        .out_l(out_l), .out_r(out_r), .gain_now(gain_now)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_out(input int x, input int g);
        longint p;
        p = longint'(x) * longint'(g);
        p = p >>> 10;
        if (p > 32767) p = 32767;
        if (p < -32767) p = -32767;
        return int'(p);
    endfunction

    function automatic int lim(input int v);
        return (v > 1024) ? 1024 : v;
    endfunction

    function automatic int pat(input int i, input int ch);
        case ((i + ch) % 8)
            0: return 32767;
            1: return -32768;
            2: return -1;
            3: return 1;
            default: return int'($signed(16'((i * 7919 + ch * 104729) & 16'hFFFF)));
        endcase
    endfunction

    task automatic do_frame(input int l, input int r, input bit we, input int val);
        int el, er;
        @(negedge clk);
        in_l = 16'(l); in_r = 16'(r);
        frame_stb = 1'b1; tgt_we = we; tgt_val = 11'(val);
        el = exp_out(l, mgain);
        er = exp_out(r, mgain);
        if (mgain < mtgt) mgain++;
        else if (mgain > mtgt) mgain--;
        if (we) mtgt = lim(val);
        @(negedge clk);
        frame_stb = 1'b0; tgt_we = 1'b0;
        chk("R3 gain step", int'(gain_now), mgain);
        chk("R7 left out", int'(out_l), el);
        chk("R7 right out", int'(out_r), er);
    endtask

    task automatic write_tgt(input int val);
        @(negedge clk);
        tgt_we = 1'b1; tgt_val = 11'(val);
        @(negedge clk);
        tgt_we = 1'b0;
        mtgt = lim(val);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int g0, ol, orr;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk("R1 gain", int'(gain_now), 0);
        chk("R1 out_l", int'(out_l), 0);
        chk("R1 out_r", int'(out_r), 0);
        // R4 parked at zero target
        do_frame(1000, -1000, 0, 0);
        chk("R4 zero hold", int'(gain_now), 0);
        // R9 write on a strobe: step uses old target 0, R2 clamps 0x7FF
        do_frame(500, 500, 1, 'h7FF);
        chk("R9 coincident write", int'(gain_now), 0);
        // R10 full ramp, R3/R7 sweep along the way
        for (int i = 0; i < 1024; i++) begin
            do_frame(pat(i, 0), pat(i, 1), 0, 0);
            if (i == 1022) chk("R10 after 1023", int'(gain_now), 'h3FF);
            if (i == 1023) chk("R10 after 1024", int'(gain_now), 'h400);
        end
        // R2 clamp: target stays unity, no further rise; R4 hold
        for (int i = 0; i < 5; i++) do_frame(pat(i, 1), pat(i, 0), 0, 0);
        chk("R2 clamp unity", int'(gain_now), 'h400);
        // R8 symmetric saturation at unity
        do_frame(-32768, 32767, 0, 0);
        chk("R8 neg rail", int'(out_l), -32767);
        chk("R8 pos rail", int'(out_r), 32767);
        // R7 hold between strobes, R3 no step without strobe
        g0 = int'(gain_now); ol = int'(out_l); orr = int'(out_r);
        write_tgt('h100);
        repeat (7) @(negedge clk);
        chk("R3 no strobe", int'(gain_now), g0);
        chk("R7 hold l", int'(out_l), ol);
        chk("R7 hold r", int'(out_r), orr);
        // R5 retarget beyond old target mid-ramp
        for (int i = 0; i < 50; i++) do_frame(pat(i + 3, 0), pat(i + 5, 1), 0, 0);
        chk("R5 mid ramp", int'(gain_now), 'h400 - 50);
        write_tgt('h080);
        while (mgain != 'h080) begin
            if (mgain == 'h100) begin
                do_frame(12345, -12345, 0, 0);
                chk("R5 pass through old target", int'(gain_now), 'hFF);
            end else begin
                do_frame(pat(mgain, 0), pat(mgain, 1), 0, 0);
            end
        end
        for (int i = 0; i < 3; i++) do_frame(-7, 7, 0, 0);
        chk("R4 parked", int'(gain_now), 'h080);
        // R6 reversal mid-ramp
        write_tgt(0);
        for (int i = 0; i < 20; i++) do_frame(pat(i, 0), pat(i, 1), 0, 0);
        chk("R6 before reverse", int'(gain_now), 'h080 - 20);
        write_tgt('h300);
        do_frame(20000, -20000, 0, 0);
        chk("R6 reversed", int'(gain_now), 'h080 - 19);
        for (int i = 0; i < 10; i++) do_frame(pat(i + 9, 0), pat(i + 2, 1), 0, 0);
        // R9 coincident reverse write: this strobe still rises
        g0 = int'(gain_now);
        do_frame(300, -300, 1, 0);
        chk("R9 step old target", int'(gain_now), g0 + 1);
        do_frame(300, -300, 0, 0);
        chk("R9 new target next", int'(gain_now), g0);
        // R4 write equal to current gain parks it
        write_tgt(int'(gain_now));
        g0 = int'(gain_now);
        for (int i = 0; i < 4; i++) do_frame(pat(i, 0), pat(i, 1), 0, 0);
        chk("R4 equal target", int'(gain_now), g0);
        finish_run();
    end
endmodule